// File: doc/BRIEF.md
# PWM Prescaler Clock Generator

This block derives a family of clock-enable strobes from one master clock for a small group of PWM channels. A free-running prescale counter provides eleven power-of-two taps, from the undivided clock up to divide-by-1024. Every output is a one-cycle enable pulse in the master clock domain, not a derived clock. Two programmable linear dividers, A and B, each pick one tap as their source. Each divider then divides that tap by its own 8-bit factor.

A global enable stands in for power-management gating of the master clock. While the enable is low, or while reset is asserted, only the undivided strobe stays active. All counters return to their starting point. Channels select one of the thirteen strobes and advance their own counters on it.

Top module: `pwm_clkgen`

## Requirements
- R1: `tap_o[0]` (divide-by-1) is 1 in every cycle, including during reset and while `en_i` is low.
- R2: With `en_i` high, `tap_o[k]` for k = 1..10 is a one-cycle pulse with a period of 2^k cycles. Counting the first cycle in which `en_i` is high as cycle 0, it is high in the cycles n where (n+1) mod 2^k = 0.
- R3: Whenever `tap_o[k]` is high for k ≥ 2, `tap_o[k-1]` is high in the same cycle.
- R4: While `en_i` is low, `tap_o[10:1]`, `clka_o` and `clkb_o` are 0. When `en_i` rises again, the prescale counter restarts as in R2.
- R5: While `rst_ni` is low, `tap_o[10:1]`, `clka_o` and `clkb_o` are 0.
- R6: With a non-zero factor F and a select code S from 0 to 10, a divider output pulses once every F·2^S cycles. Here S is the tap index: code S picks `tap_o[S]`.
- R7: A divider output is high only in a cycle in which its selected source tap is high.
- R8: A select code from 11 to 15 keeps that divider's output at 0.
- R9: A factor of 0 keeps that divider's output at 0.
- R10: A factor written while the divider runs takes effect after the divider's next output pulse. A factor present while `en_i` is low is used from the first pulse after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Master clock enable (power-management stand-in) |
| diva_fact_i | input | 8 | Divider A factor, 0 = off |
| diva_sel_i | input | 4 | Divider A source tap index |
| divb_fact_i | input | 8 | Divider B factor, 0 = off |
| divb_sel_i | input | 4 | Divider B source tap index |
| tap_o | output | 11 | Power-of-two enable strobes, bit k = divide by 2^k |
| clka_o | output | 1 | Divider A enable strobe |
| clkb_o | output | 1 | Divider B enable strobe |

## Verification
The taps are compared cycle by cycle against the 2^k pattern over a full 2048-cycle span after enable. A wrong tap index or an off-by-one counter phase shows up at once. The dividers are run with a table of factor/select pairs. The pairs mix factor 1, factor 255, odd and even factors, and sources from the undivided tap to divide-by-1024. Measuring the gap between successive pulses separates an error in the factor count from an error in the source choice. Directed cases cover factor 0, select codes out of range, a factor change in mid-run, and dropping the enable or reset in mid-run.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;
  parameter int unsigned N_TAPS = 11;
  parameter int unsigned FACT_W = 8;
  parameter int unsigned SEL_W  = 4;
  parameter int unsigned N_DIV  = 2;
  localparam int unsigned CNT_W = N_TAPS - 1;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_clkgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [N_TAPS-1:0] tap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tap_o[0] = 1'b1;
  for (genvar k = 1; k < N_TAPS; k++) begin : g_tap
    // tap k fires when the low k bits are all ones
    assign tap_o[k] = en_i & (&cnt_q[k-1:0]);
  end
endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div
  import pwm_clkgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [N_TAPS-1:0] taps_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [FACT_W-1:0] fact_i,
  output logic              pulse_o
);
  localparam int unsigned PAD_W = 2**SEL_W;

  logic [PAD_W-1:0]  taps_pad;
  logic              src;
  logic [FACT_W-1:0] fact_q, cnt_q;
  logic              wrap;

  assign taps_pad = PAD_W'(taps_i);
  assign src      = taps_pad[sel_i];
  assign wrap     = en_i && (fact_q != '0) && src && (cnt_q == fact_q - 1'b1);
  assign pulse_o  = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fact_q <= '0;
    end else if (!en_i || fact_q == '0) begin
      cnt_q  <= '0;
      fact_q <= fact_i;
    end else if (wrap) begin
      cnt_q  <= '0;
      fact_q <= fact_i;
    end else if (src) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
  import pwm_clkgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FACT_W-1:0] diva_fact_i,
  input  logic [SEL_W-1:0]  diva_sel_i,
  input  logic [FACT_W-1:0] divb_fact_i,
  input  logic [SEL_W-1:0]  divb_sel_i,
  output logic [N_TAPS-1:0] tap_o,
  output logic              clka_o,
  output logic              clkb_o
);
  logic [N_TAPS-1:0] taps;
  logic [FACT_W-1:0] fact [N_DIV];
  logic [SEL_W-1:0]  sel  [N_DIV];
  logic [N_DIV-1:0]  div_pulse;

  pwm_prescaler i_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tap_o  (taps)
  );

  assign fact[0] = diva_fact_i;
  assign sel[0]  = diva_sel_i;
  assign fact[1] = divb_fact_i;
  assign sel[1]  = divb_sel_i;

  for (genvar d = 0; d < N_DIV; d++) begin : g_div
    pwm_lin_div i_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .taps_i  (taps),
      .sel_i   (sel[d]),
      .fact_i  (fact[d]),
      .pulse_o (div_pulse[d])
    );
  end

  assign tap_o  = taps;
  assign clka_o = div_pulse[0];
  assign clkb_o = div_pulse[1];
endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk
  import pwm_clkgen_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [SEL_W-1:0]  diva_sel_i,
  input logic [SEL_W-1:0]  divb_sel_i,
  input logic [N_TAPS-1:0] tap_o,
  input logic              clka_o,
  input logic              clkb_o
);
  localparam int unsigned PAD_W = 2**SEL_W;
  logic [PAD_W-1:0] taps_pad;
  assign taps_pad = PAD_W'(tap_o);

  // R4
  gated_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (tap_o[N_TAPS-1:1] == '0) && !clka_o && !clkb_o);

  // R3
  tap_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_o[N_TAPS-1:2] & ~tap_o[N_TAPS-2:1]) == '0);

  // R2
  tap1_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tap_o[1]) |=> !tap_o[1]);

  // R7
  diva_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clka_o |-> taps_pad[diva_sel_i]);

  // R7
  divb_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkb_o |-> taps_pad[divb_sel_i]);

  // R8
  diva_badsel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diva_sel_i >= SEL_W'(N_TAPS)) |-> !clka_o);

  // R1
  always_comb begin
    div1_on_chk: assert (tap_o[0] === 1'b1 || $isunknown(tap_o));
  end
endmodule

bind pwm_clkgen pwm_clkgen_chk i_pwm_clkgen_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .diva_sel_i (diva_sel_i),
  .divb_sel_i (divb_sel_i),
  .tap_o      (tap_o),
  .clka_o     (clka_o),
  .clkb_o     (clkb_o)
);

// File: tb/test_pwm_clkgen.sv
`timescale 1ns/1ps
module test_pwm_clkgen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [7:0]  diva_fact_i = 8'd0, divb_fact_i = 8'd0;
  logic [3:0]  diva_sel_i = 4'd0, divb_sel_i = 4'd0;
  logic [10:0] tap_o;
  logic        clka_o, clkb_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  pwm_clkgen i_pwm_clkgen (
    .clk_i, .rst_ni, .en_i,
    .diva_fact_i, .diva_sel_i, .divb_fact_i, .divb_sel_i,
    .tap_o, .clka_o, .clkb_o
  );

  typedef struct packed {
    logic [3:0]  sa; logic [7:0] fa; logic [31:0] pa;
    logic [3:0]  sb; logic [7:0] fb; logic [31:0] pb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0,  8'd1,   32'd1,    4'd1, 8'd1,   32'd2},
    '{4'd0,  8'd3,   32'd3,    4'd0, 8'd255, 32'd255},
    '{4'd1,  8'd5,   32'd10,   4'd2, 8'd4,   32'd16},
    '{4'd3,  8'd2,   32'd16,   4'd4, 8'd7,   32'd112},
    '{4'd5,  8'd3,   32'd96,   4'd0, 8'd2,   32'd2},
    '{4'd10, 8'd1,   32'd1024, 4'd6, 8'd3,   32'd192},
    '{4'd2,  8'd200, 32'd800,  4'd1, 8'd9,   32'd18},
    '{4'd0,  8'd128, 32'd128,  4'd3, 8'd50,  32'd400}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_taps(input int n);
    logic [10:0] e;
    e[0] = 1'b1;
    for (int k = 1; k < 11; k++) e[k] = (((n + 1) % (1 << k)) == 0);
    return e;
  endfunction

  task automatic quiet_chk(input string req);
    chk({req, " taps"}, 32'(tap_o), 32'h1);
    chk({req, " clka"}, 32'(clka_o), 32'h0);
    chk({req, " clkb"}, 32'(clkb_o), 32'h0);
  endtask

  // drop enable, load config, raise enable; leaves time at n=0 sample point
  task automatic restart();
    @(negedge clk_i); en_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    en_i = 1'b1; #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R5 R1: reset state with enable high
    en_i = 1'b1; diva_fact_i = 8'd1; divb_fact_i = 8'd1;
    repeat (3) @(negedge clk_i);
    #1 quiet_chk("R5 R1 reset");
    @(negedge clk_i); rst_ni = 1'b1; en_i = 1'b0;

    // R2 R1: full tap pattern after enable
    restart();
    for (int n = 0; n < 2048; n++) begin
      if (n > 0) begin @(negedge clk_i); #1; end
      chk($sformatf("R2 R1 taps n=%0d", n), 32'(tap_o), 32'(exp_taps(n)));
    end

    // R4: gating in mid-run, then restart phase
    @(negedge clk_i); en_i = 1'b0; #1;
    quiet_chk("R4 gated");
    repeat (5) begin @(negedge clk_i); #1; end
    quiet_chk("R4 gated hold");
    @(negedge clk_i); en_i = 1'b1; #1;
    for (int n = 0; n < 16; n++) begin
      if (n > 0) begin @(negedge clk_i); #1; end
      chk($sformatf("R4 restart n=%0d", n), 32'(tap_o), 32'(exp_taps(n)));
    end

    // R6 R7 R10: divider table
    foreach (VECS[i]) begin
      int fa_t, ga, fb_t, gb;
      @(negedge clk_i); en_i = 1'b0;
      diva_sel_i = VECS[i].sa; diva_fact_i = VECS[i].fa;
      divb_sel_i = VECS[i].sb; divb_fact_i = VECS[i].fb;
      restart();
      fa_t = -1; ga = -1; fb_t = -1; gb = -1;
      for (int n = 0; n < 3000 && (ga < 0 || gb < 0); n++) begin
        if (n > 0) begin @(negedge clk_i); #1; end
        if (clka_o) begin
          if (tap_o[VECS[i].sa] !== 1'b1) chk("R7 clka source", 32'(tap_o), 32'(1 << VECS[i].sa));
          if (fa_t < 0) fa_t = n; else if (ga < 0) ga = n - fa_t;
        end
        if (clkb_o) begin
          if (tap_o[VECS[i].sb] !== 1'b1) chk("R7 clkb source", 32'(tap_o), 32'(1 << VECS[i].sb));
          if (fb_t < 0) fb_t = n; else if (gb < 0) gb = n - fb_t;
        end
      end
      chk($sformatf("R6 R10 clka period vec%0d", i), 32'(ga), VECS[i].pa);
      chk($sformatf("R6 R10 clkb period vec%0d", i), 32'(gb), VECS[i].pb);
    end

    // R9 R8: factor zero on A, out-of-range select on B
    begin
      int pa_n, pb_n;
      @(negedge clk_i); en_i = 1'b0;
      diva_sel_i = 4'd0; diva_fact_i = 8'd0;
      divb_sel_i = 4'd12; divb_fact_i = 8'd1;
      restart();
      pa_n = 0; pb_n = 0;
      for (int n = 0; n < 200; n++) begin
        if (n > 0) begin @(negedge clk_i); #1; end
        pa_n += int'(clka_o); pb_n += int'(clkb_o);
      end
      chk("R9 factor zero pulses", 32'(pa_n), 32'd0);
      chk("R8 select 12 pulses", 32'(pb_n), 32'd0);
      @(negedge clk_i); divb_sel_i = 4'd15; #1;
      pb_n = 0;
      for (int n = 0; n < 50; n++) begin @(negedge clk_i); #1; pb_n += int'(clkb_o); end
      chk("R8 select 15 pulses", 32'(pb_n), 32'd0);
    end

    // R10: factor change in mid-run lands after next wrap
    begin
      int t0, t1, t2;
      @(negedge clk_i); en_i = 1'b0;
      diva_sel_i = 4'd0; diva_fact_i = 8'd4;
      restart();
      while (!clka_o) begin @(negedge clk_i); #1; end
      @(negedge clk_i); diva_fact_i = 8'd2; #1;
      t0 = 0; t1 = -1; t2 = -1;
      for (int n = 1; n < 40 && t2 < 0; n++) begin
        @(negedge clk_i); #1;
        if (clka_o) begin if (t1 < 0) t1 = n; else t2 = n; end
      end
      chk("R10 gap with old factor", 32'(t1 + 1), 32'd4);
      chk("R10 gap with new factor", 32'(t2 - t1), 32'd2);
    end

    // R5: asynchronous reset in mid-run
    @(negedge clk_i); diva_fact_i = 8'd1; divb_sel_i = 4'd0; divb_fact_i = 8'd1;
    repeat (7) @(negedge clk_i);
    #1 rst_ni = 1'b0; #1;
    quiet_chk("R5 async reset");
    @(negedge clk_i); rst_ni = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule